// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

A free-running 16-bit up-counter that an 8-bit bus reads one byte at a time. Each count step is gated by an enable pulse from a selectable clock source. The source is one of seven power-of-two divisions of the bus clock (1 through 64), or an external pin. The pin is brought into the bus clock domain by a two-flop synchronizer and a rising-edge detector, so the whole block runs on one clock.

Software writes a control register. That register holds a 3-bit source select and a self-clearing counter-clear bit. Software reads the count as two byte registers. A high-byte read captures the live low byte in a buffer. The following low-byte read returns that buffer, so a high-then-low read sequence yields one coherent 16-bit sample even while the counter keeps running. Address decoding is reduced to a 2-bit register select on separate read and write strobes.

Top module: `prescaled_timer16`

## Requirements
- R1: During and after reset, the count is 0x0000, the source select is 000 and no low-byte capture is pending. The `rd_data` output is combinational and valid while reset is asserted.
- R2: Select codes 000 to 110 advance the counter at the bus clock divided by 2^code: 1, 2, 4, 8, 16, 32 or 64. Over any window of W cycles, with W a multiple of the division, the count grows by exactly W divided by the division.
- R3: Select code 111 advances the counter by exactly one for each rising edge of `ext_clk_in`, and by nothing while the pin is held. The pin must stay at each level for at least two bus cycles.
- R4: The counter wraps from 0xFFFF to 0x0000.
- R5: A control write with data bit 4 set clears the counter to 0x0000 at that clock edge. The clear takes priority over a count step in the same cycle.
- R6: Writes with `wr_sel` 01 (count high) or 10 (count low) change neither the count nor the control register.
- R7: A read with `rd_sel` 01 returns count bits 15:8. When no capture is pending, it also copies count bits 7:0 from that same cycle into the buffer. The next read with `rd_sel` 10 returns the buffered byte.
- R8: Further high-byte reads while a capture is pending leave the buffer unchanged. Only a low-byte read releases it, and without that read the buffer holds its value indefinitely.
- R9: A low-byte read while no capture is pending returns the live count bits 7:0.
- R10: A read with `rd_sel` 00 returns the control register: bits 2:0 hold the source select and all other bits, the clear bit 4 included, read 0. A read with `rd_sel` 11 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_in | input | 1 | External count pin, asynchronous to `clk` |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 00 control, 01 count high, 10 count low, 11 none |
| wr_data | input | 8 | Write data; control uses bits 2:0 (select) and bit 4 (clear) |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | 8 | Read data, combinational from `rd_sel` and current state |

## Verification
The assertions check the per-cycle relations on every cycle:
- a clear forces zero;
- an enable pulse adds exactly one and its absence holds the count;
- divide-by-1 enables every cycle;
- a first high-byte read captures the low byte of that cycle;
- a pending buffer stays frozen until a low-byte read releases it.

Some properties emerge only over many cycles, and only the bench scenarios show them:
- the division rate of each tap over a long window;
- the exact count of synchronized external edges;
- the wrap through 0xFFFF;
- writes to the count registers leaving state untouched.

// File: rtl/ptmr_pkg.sv
// Package: shared encodings for the prescaled timer.
// Assumes a byte-wide bus and a 2-bit register select.
package ptmr_pkg;
    localparam int SEL_W   = 3;
    localparam int BYTE_W  = 8;
    localparam int CLR_BIT = 4;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'b00,
        REG_CNT_HI = 2'b01,
        REG_CNT_LO = 2'b10,
        REG_NONE   = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/ptmr_prescaler.sv
// Module: count-enable generator.
// A free-running divider supplies 2^SEL_W-1 power-of-two taps; the last
// select code picks a synchronized, rising-edge-detected external pin.
// Assumes the external pin holds each level for at least two clk cycles.
module ptmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_pin,
    output logic             tick
);
    localparam int NUM_SRC  = 2 ** SEL_W;
    localparam int DIV_BITS = NUM_SRC - 2;

    logic [DIV_BITS-1:0] div_q;
    logic [NUM_SRC-1:0]  src;
    logic                ext_meta, ext_sync, ext_prev;

    // Free-running divider shared by every tap.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Two-flop synchronizer plus a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_meta <= 1'b0;
            ext_sync <= 1'b0;
            ext_prev <= 1'b0;
        end else begin
            ext_meta <= ext_pin;
            ext_sync <= ext_meta;
            ext_prev <= ext_sync;
        end
    end

    // Tap k pulses once every 2^k cycles, when the low k divider bits are all ones.
    assign src[0] = 1'b1;
    for (genvar k = 1; k < NUM_SRC - 1; k++) begin : g_tap
        assign src[k] = &div_q[k-1:0];
    end
    assign src[NUM_SRC-1] = ext_sync & ~ext_prev;

    // Source multiplexer.
    assign tick = src[sel];
endmodule

// File: rtl/ptmr_counter.sv
// Module: up-counter with synchronous clear.
// Wraps at the top; clear wins over a step in the same cycle.
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    // Count register: clear, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (tick)     count <= count + 1'b1;
    end
endmodule

// File: rtl/ptmr_read_latch.sv
// Module: low-byte capture buffer for coherent two-byte reads.
// The first capture request arms the buffer; a release empties it.
// Assumes capture and release never arrive in the same cycle.
module ptmr_read_latch #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              rel,
    input  logic [BYTE_W-1:0] live_lo,
    output logic              pending,
    output logic [BYTE_W-1:0] held
);
    // Pending flag and held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            held    <= '0;
        end else if (rel) begin
            pending <= 1'b0;
        end else if (cap && !pending) begin
            pending <= 1'b1;
            held    <= live_lo;
        end
    end
endmodule

// File: rtl/prescaled_timer16.sv
// Module: prescaled 16-bit timer counter with a byte-wide register view.
// Holds the control register, decodes the strobes and muxes read data.
// Assumes one strobe per cycle per direction; rd_data is combinational.
module prescaled_timer16
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_data
);
    logic [SEL_W-1:0]  sel_q;
    logic              ctrl_wr, cnt_clr, cnt_tick;
    logic [CNT_W-1:0]  cnt_q;
    logic              lo_pending;
    logic [BYTE_W-1:0] lo_held;
    logic              rd_hi, rd_lo;
    logic              unused_wdata;

    assign ctrl_wr      = wr_en && (wr_sel == REG_CTRL);
    assign cnt_clr      = ctrl_wr && wr_data[CLR_BIT];
    assign rd_hi        = rd_en && (rd_sel == REG_CNT_HI);
    assign rd_lo        = rd_en && (rd_sel == REG_CNT_LO);
    assign unused_wdata = ^{wr_data[BYTE_W-1:CLR_BIT+1], wr_data[CLR_BIT-1:SEL_W]};

    // Source select register; only control writes reach it.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (ctrl_wr) sel_q <= wr_data[SEL_W-1:0];
    end

    ptmr_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .ext_pin(ext_clk_in), .tick(cnt_tick)
    );

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(cnt_tick), .count(cnt_q)
    );

    ptmr_read_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .cap(rd_hi), .rel(rd_lo),
        .live_lo(cnt_q[BYTE_W-1:0]), .pending(lo_pending), .held(lo_held)
    );

    // Read data multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            REG_CTRL:   rd_data[SEL_W-1:0] = sel_q;
            REG_CNT_HI: rd_data = cnt_q[CNT_W-1 -: BYTE_W];
            REG_CNT_LO: rd_data = lo_pending ? lo_held : cnt_q[BYTE_W-1:0];
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptmr_checker.sv
// Module: cycle-level property checker, bound into prescaled_timer16.
module ptmr_checker
    import ptmr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [7:0]  wr_data,
    input logic        rd_en,
    input logic [1:0]  rd_sel,
    input logic [2:0]  sel_q,
    input logic        tick,
    input logic [15:0] count,
    input logic        pending,
    input logic [7:0]  held
);
    logic clr_req;
    assign clr_req = wr_en && (wr_sel == REG_CTRL) && wr_data[CLR_BIT];

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (count == 16'h0000));

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && tick) |=> (count == 16'($past(count) + 16'd1)));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !tick) |=> $stable(count));

    p_div1_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd0) |-> tick);

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == REG_CNT_HI && !pending) |=> (pending && held == $past(count[7:0])));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(rd_en && rd_sel == REG_CNT_LO)) |=> (pending && $stable(held)));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == REG_CNT_LO) |=> !pending);

    p_ext_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd7 && tick && !(wr_en && wr_sel == REG_CTRL)) |=> !tick);
endmodule

bind prescaled_timer16 ptmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .sel_q(sel_q), .tick(cnt_tick),
    .count(cnt_q), .pending(lo_pending), .held(lo_held)
);

// File: tb/prescaled_timer16_test.sv
module prescaled_timer16_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b11;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'b11;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] hi, lo;

    // Vector: {select[26:24], window[23:12], expected delta[11:0]}
    localparam logic [26:0] VECS [0:7] = '{
        {3'd0, 12'd192, 12'd192}, {3'd1, 12'd192, 12'd96},
        {3'd2, 12'd192, 12'd48},  {3'd3, 12'd192, 12'd24},
        {3'd4, 12'd192, 12'd12},  {3'd5, 12'd192, 12'd6},
        {3'd6, 12'd192, 12'd3},   {3'd7, 12'd192, 12'd0}
    };

    prescaled_timer16 uut (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    task automatic read_reg(input logic [1:0] s, output logic [7:0] d);
        rd_en = 1'b1; rd_sel = s;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0; rd_sel = 2'b11;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state, read while reset is held
        step(3);
        rd_en = 1'b1; rd_sel = 2'b01; #1; check("R1 high byte in reset", {8'h0, rd_data}, 16'h0);
        rd_sel = 2'b10; #1; check("R1 low byte in reset", {8'h0, rd_data}, 16'h0);
        rd_sel = 2'b00; #1; check("R1 control in reset", {8'h0, rd_data}, 16'h0);
        rd_en = 1'b0; rd_sel = 2'b11;
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(1);

        // R2 / R3: division-rate vectors
        for (int i = 0; i < 8; i++) begin
            write_reg(2'b00, {3'b000, 1'b1, 1'b0, VECS[i][26:24]});
            step(int'(VECS[i][23:12]));
            read_reg(2'b01, hi);
            read_reg(2'b10, lo);
            check($sformatf("R2 rate sel=%0d", VECS[i][26:24]), {hi, lo}, {4'h0, VECS[i][11:0]});
        end

        // R3: five external rising edges
        write_reg(2'b00, 8'h17);
        for (int i = 0; i < 5; i++) begin
            ext_clk_in = 1'b1; step(3);
            ext_clk_in = 1'b0; step(3);
        end
        step(4);
        read_reg(2'b01, hi);
        read_reg(2'b10, lo);
        check("R3 external edge count", {hi, lo}, 16'd5);

        // R6 / R10: writes to count registers ignored; control readback
        write_reg(2'b01, 8'hAB);
        write_reg(2'b10, 8'hCD);
        read_reg(2'b00, lo);
        check("R10 control readback clear reads 0", {8'h0, lo}, 16'h0007);
        read_reg(2'b01, hi);
        read_reg(2'b10, lo);
        check("R6 count writes ignored", {hi, lo}, 16'h0005);
        read_reg(2'b11, lo);
        check("R10 unused select reads 0", {8'h0, lo}, 16'h0);

        // R7 / R8 / R9: coherent capture in divide-by-1
        write_reg(2'b00, 8'h10);        // count 0
        step(10);                       // count 10
        read_reg(2'b01, hi);            // captures 0x0A, count 11
        check("R7 high byte live", {8'h0, hi}, 16'h00);
        step(5);                        // count 16
        read_reg(2'b01, hi);            // no recapture, count 17
        step(300);                      // count 317
        read_reg(2'b10, lo);            // buffered, count 318
        check("R8 buffer held across high reads", {8'h0, lo}, 16'h000A);
        read_reg(2'b10, lo);            // live 318, count 319
        check("R9 live low byte", {8'h0, lo}, 16'h003E);
        read_reg(2'b01, hi);            // count 319
        check("R7 high byte after release", {8'h0, hi}, 16'h0001);
        read_reg(2'b10, lo);            // buffered 319 low byte
        check("R7 low byte coherent", {8'h0, lo}, 16'h003F);

        // R4: wrap from 0xFFFF
        write_reg(2'b00, 8'h10);
        step(65535);                    // count 0xFFFF
        read_reg(2'b01, hi);            // count wraps to 0
        read_reg(2'b10, lo);            // count 1
        check("R4 top value", {hi, lo}, 16'hFFFF);
        read_reg(2'b01, hi);            // count 1 -> 2
        read_reg(2'b10, lo);
        check("R4 wrapped to zero", {hi, lo}, 16'h0001);

        // R5: clear while running
        step(700);
        write_reg(2'b00, 8'h10);        // count 0
        read_reg(2'b10, lo);
        check("R5 clear while running", {8'h0, lo}, 16'h0000);
        read_reg(2'b00, lo);
        check("R5 clear bit self-clears", {8'h0, lo}, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule